// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a two-wire serial slave that lets a bus master load and read back the configuration of a clock-generation datapath. The serial clock and data lines are oversampled on the system clock. Start and stop conditions are detected internally. A fixed 7-bit device address selects the block. The first byte of a write sets an 8-bit register pointer, and every later byte of the same transfer is stored at the pointer, which then advances by one.

Only eleven locations of the 256-entry address space hold storage. The remaining locations ignore writes and read as zero. Some stored registers contain bits that always hold a fixed pattern, whatever value the master writes. To read, the master first writes the pointer, then issues a repeated start with the read bit set. It then clocks out successive registers until it answers with a NACK. All stored registers are presented in parallel to the downstream clock logic.

Top module: `tw_cfg_slave`

## Requirements
- R1: After reset every stored register is 00H, the data line is released (`sda_pull_o`=0) and `resv_wr_o` is 0.
- R2: A start is SDA falling while SCL is high; a stop is SDA rising while SCL is high. Bytes clocked without a preceding start get no acknowledge, and a stop returns the slave to idle with SDA released.
- R3: The first byte after a start is the device address 1101001 in bits 7..1 plus a direction bit in bit 0 (0 = write, 1 = read). On a match the slave pulls SDA low in the 9th clock. On a mismatch it does not acknowledge and ignores the bus until the next start.
- R4: In a write transfer the second byte loads the register pointer and later bytes are stored. The slave acknowledges each byte by holding SDA low during the 9th clock. SDA changes only while SCL is low.
- R5: After each data byte, written or read, the pointer advances by one, and it wraps from FFH to 00H.
- R6: A read is a write of the pointer followed by a repeated start with direction 1. The slave sends the register at the pointer MSB first and, after each master ACK (SDA low in the 9th clock), sends the next register. A master NACK (SDA high) ends the transfer.
- R7: Only addresses 09H, 0CH, 12H, 13H, 40H, 41H, 42H, 44H, 45H, 46H and 47H hold storage. A write to any other address changes nothing, is still acknowledged, and sets `resv_wr_o`, which stays set until reset. Reads of those addresses return 00H.
- R8: Writes store fixed bits regardless of the data: 09H bits 7..6 = 00, 12H = 001 in bits 7..5 and 000 in bits 2..0 (only bits 4..3 writable), 40H bits 7..5 = 110, 46H bits 5..0 = 111111.
- R9: `cfg_image_o` bits [8k+7:8k] carry stored register k, where k = 0..10 follows the ascending address order 09H, 0CH, 12H, 13H, 40H, 41H, 42H, 44H, 45H, 46H, 47H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_pull_o | output | 1 | 1 = pull the data line low (open-drain enable) |
| cfg_image_o | output | 88 | Parallel image of the eleven stored registers |
| resv_wr_o | output | 1 | Sticky flag: a write hit an unimplemented address |

## Verification
The bench builds the block with its default parameters: device address 69H, two synchronizer stages and a bus quarter-period of five system clocks. That setting is short enough that a single burst can write all 256 pointer values and a second burst can read all of them back. Every address is therefore covered: stored, reserved, masked bits and pointer wrap, each compared with a value the bench computes itself. Directed transfers add the cases a sweep does not reach: a mismatched address, bytes clocked without a start, a burst that wraps into a stored register, and reads that end on a NACK.

// File: rtl/tw_regs_pkg.sv
package tw_regs_pkg;

    localparam int NREG = 11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_PTR,
        ST_WR,
        ST_RD
    } tw_state_e;

    // Address of stored register k (ascending order defines image layout).
    function automatic logic [7:0] reg_addr(input int k);
        case (k)
            0:       return 8'h09;
            1:       return 8'h0C;
            2:       return 8'h12;
            3:       return 8'h13;
            4:       return 8'h40;
            5:       return 8'h41;
            6:       return 8'h42;
            7:       return 8'h44;
            8:       return 8'h45;
            9:       return 8'h46;
            default: return 8'h47;
        endcase
    endfunction

    // Bits the master may change in register k.
    function automatic logic [7:0] keep_mask(input int k);
        case (k)
            0:       return 8'h3F;
            2:       return 8'h18;
            4:       return 8'h1F;
            9:       return 8'hC0;
            default: return 8'hFF;
        endcase
    endfunction

    // Value of the non-writable bits of register k after a write.
    function automatic logic [7:0] force_val(input int k);
        case (k)
            2:       return 8'h20;
            4:       return 8'hC0;
            9:       return 8'h3F;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], line_i};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '1;           // idle bus lines are high
        end else begin
            s_q <= s_d;
        end
    end

    assign level_o = s_q.chain[STAGES-1];
    assign rise_o  = s_q.chain[STAGES-1] & ~s_q.prev;
    assign fall_o  = ~s_q.chain[STAGES-1] & s_q.prev;

endmodule

// File: rtl/tw_regfile.sv
module tw_regfile
    import tw_regs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [7:0]      wr_addr,
    input  logic [7:0]      wr_data,
    input  logic [7:0]      rd_addr,
    output logic [7:0]      rd_data,
    output logic [NREG*8-1:0] image_o,
    output logic            resv_wr_o
);
    typedef struct packed {
        logic [NREG-1:0][7:0] data;
        logic                 resv;
    } rf_t;

    rf_t r_d, r_q;
    logic wr_hit;

    always_comb begin
        r_d    = r_q;
        wr_hit = 1'b0;
        for (int k = 0; k < NREG; k++) begin
            if (wr_addr == reg_addr(k)) begin
                wr_hit = 1'b1;
                if (wr_en) begin
                    r_d.data[k] = (wr_data & keep_mask(k)) | (force_val(k) & ~keep_mask(k));
                end
            end
        end
        if (wr_en && !wr_hit) begin
            r_d.resv = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_data = 8'h00;
        for (int k = 0; k < NREG; k++) begin
            if (rd_addr == reg_addr(k)) begin
                rd_data = rd_data | r_q.data[k];
            end
        end
    end

    assign image_o   = r_q.data;
    assign resv_wr_o = r_q.resv;

    // R7: a write to an unimplemented address leaves all storage untouched
    assert_resv_wr_no_effect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hit) |=> $stable(image_o));

    // R7: the reserved-write flag never clears once set
    assert_resv_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resv_wr_o |=> resv_wr_o);

    for (genvar g = 0; g < NREG; g++) begin : g_fixed
        localparam logic [7:0] ADDR = reg_addr(g);
        localparam logic [7:0] KEEP = keep_mask(g);
        localparam logic [7:0] FRC  = force_val(g);
        // R8: after a write the non-writable bits hold the fixed pattern
        assert_fixed_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == ADDR) |=> ((image_o[g*8 +: 8] & ~KEEP) == (FRC & ~KEEP)));
    end

endmodule

// File: rtl/tw_proto.sv
module tw_proto
    import tw_regs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_lvl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_lvl,
    input  logic       sda_rise,
    input  logic       sda_fall,
    input  logic [7:0] rd_data,
    output logic [7:0] ptr_o,
    output logic       wr_en,
    output logic [7:0] wr_data,
    output logic       sda_pull_o
);
    localparam logic [3:0] BITS    = 4'd8;
    localparam logic [3:0] ACK_CNT = BITS + 4'd1;

    typedef struct packed {
        tw_state_e  st;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic [7:0] ptr;
        logic       rw;
        logic       oe;
        logic       nack;
    } proto_t;

    proto_t p_d, p_q;
    logic start_ev, stop_ev;

    assign start_ev = scl_lvl & sda_fall;
    assign stop_ev  = scl_lvl & sda_rise;

    always_comb begin
        p_d   = p_q;
        wr_en = 1'b0;
        if (start_ev) begin
            p_d.st  = ST_DEV;
            p_d.cnt = '0;
            p_d.oe  = 1'b0;
        end else if (stop_ev) begin
            p_d.st  = ST_IDLE;
            p_d.cnt = '0;
            p_d.oe  = 1'b0;
        end else begin
            case (p_q.st)
                ST_DEV, ST_PTR, ST_WR: begin
                    if (scl_rise && p_q.cnt < BITS) begin
                        p_d.sh  = {p_q.sh[6:0], sda_lvl};
                        p_d.cnt = p_q.cnt + 4'd1;
                    end else if (scl_fall && p_q.cnt == BITS) begin
                        p_d.cnt = ACK_CNT;
                        case (p_q.st)
                            ST_DEV: begin
                                if (p_q.sh[7:1] == DEV_ADDR) begin
                                    p_d.oe = 1'b1;
                                    p_d.rw = p_q.sh[0];
                                end else begin
                                    p_d.st  = ST_IDLE;
                                    p_d.cnt = '0;
                                end
                            end
                            ST_PTR: begin
                                p_d.ptr = p_q.sh;
                                p_d.oe  = 1'b1;
                            end
                            default: begin
                                wr_en   = 1'b1;
                                p_d.ptr = p_q.ptr + 8'd1;
                                p_d.oe  = 1'b1;
                            end
                        endcase
                    end else if (scl_fall && p_q.cnt == ACK_CNT) begin
                        p_d.oe  = 1'b0;
                        p_d.cnt = '0;
                        if (p_q.st == ST_DEV) begin
                            if (p_q.rw) begin
                                p_d.st  = ST_RD;
                                p_d.sh  = rd_data;
                                p_d.ptr = p_q.ptr + 8'd1;
                                p_d.oe  = ~rd_data[7];
                            end else begin
                                p_d.st = ST_PTR;
                            end
                        end else begin
                            p_d.st = ST_WR;
                        end
                    end
                end
                ST_RD: begin
                    if (scl_rise && p_q.cnt < BITS) begin
                        p_d.cnt = p_q.cnt + 4'd1;
                    end else if (scl_rise && p_q.cnt == ACK_CNT) begin
                        p_d.nack = sda_lvl;
                    end else if (scl_fall && p_q.cnt != 4'd0 && p_q.cnt < BITS) begin
                        p_d.sh = {p_q.sh[6:0], 1'b0};
                        p_d.oe = ~p_q.sh[6];
                    end else if (scl_fall && p_q.cnt == BITS) begin
                        p_d.oe  = 1'b0;
                        p_d.cnt = ACK_CNT;
                    end else if (scl_fall && p_q.cnt == ACK_CNT) begin
                        p_d.cnt = '0;
                        if (p_q.nack) begin
                            p_d.st = ST_IDLE;
                        end else begin
                            p_d.sh  = rd_data;
                            p_d.ptr = p_q.ptr + 8'd1;
                            p_d.oe  = ~rd_data[7];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '{st: ST_IDLE, cnt: '0, sh: '0, ptr: '0, rw: 1'b0, oe: 1'b0, nack: 1'b0};
        end else begin
            p_q <= p_d;
        end
    end

    assign ptr_o      = p_q.ptr;
    assign wr_data    = p_q.sh;
    assign sda_pull_o = p_q.oe;

    // R4: the slave only starts pulling SDA while SCL is low
    assert_pull_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_lvl);

    // R2: a stop releases SDA and returns to idle
    assert_stop_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_ev && !start_ev) |=> (!sda_pull_o && p_q.st == ST_IDLE));

    // R3: a start always begins address reception
    assert_start_dev_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (p_q.st == ST_DEV && p_q.cnt == 4'd0));

    // R5: each stored byte advances the pointer by one (mod 256)
    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr_o == $past(ptr_o) + 8'd1));

endmodule

// File: rtl/tw_cfg_slave.sv
module tw_cfg_slave
    import tw_regs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_pull_o,
    output logic [NREG*8-1:0]  cfg_image_o,
    output logic               resv_wr_o
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] line_in, line_lvl, line_rise, line_fall;
    logic [7:0] ptr, wdata, rdata;
    logic       wr_en;

    assign line_in = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (line_in[g]),
            .level_o(line_lvl[g]),
            .rise_o (line_rise[g]),
            .fall_o (line_fall[g])
        );
    end

    tw_proto #(.DEV_ADDR(DEV_ADDR)) u_proto (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (line_lvl[0]),
        .scl_rise  (line_rise[0]),
        .scl_fall  (line_fall[0]),
        .sda_lvl   (line_lvl[1]),
        .sda_rise  (line_rise[1]),
        .sda_fall  (line_fall[1]),
        .rd_data   (rdata),
        .ptr_o     (ptr),
        .wr_en     (wr_en),
        .wr_data   (wdata),
        .sda_pull_o(sda_pull_o)
    );

    tw_regfile u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (ptr),
        .wr_data  (wdata),
        .rd_addr  (ptr),
        .rd_data  (rdata),
        .image_o  (cfg_image_o),
        .resv_wr_o(resv_wr_o)
    );

endmodule

// File: tb/sim_tw_cfg_slave.sv
`timescale 1ns/1ps
module sim_tw_cfg_slave;
    localparam int QTR = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_pull;
    logic [87:0] image;
    logic resv_flag;
    logic sda_line;

    int checks = 0;
    int fails = 0;
    logic [7:0] mdl [256];

    always #4 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;

    tw_cfg_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .cfg_image_o(image), .resv_wr_o(resv_flag)
    );

    function automatic logic [7:0] b_list(input int k);
        logic [7:0] t [11] = '{8'h09, 8'h0C, 8'h12, 8'h13, 8'h40, 8'h41,
                               8'h42, 8'h44, 8'h45, 8'h46, 8'h47};
        return t[k];
    endfunction

    function automatic bit b_impl(input logic [7:0] a);
        for (int k = 0; k < 11; k++) if (b_list(k) == a) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [7:0] b_store(input logic [7:0] a, input logic [7:0] v);
        case (a)
            8'h09:   return v & 8'h3F;
            8'h12:   return (v & 8'h18) | 8'h20;
            8'h40:   return (v & 8'h1F) | 8'hC0;
            8'h46:   return (v & 8'hC0) | 8'h3F;
            default: return v;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qw();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qw(); scl = 1'b1; qw(); m_sda = 1'b0; qw(); scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qw(); scl = 1'b1; qw(); m_sda = 1'b1; qw();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
        end
        m_sda = 1'b1; qw(); scl = 1'b1; qw();
        ack = (sda_line == 1'b0);
        qw(); scl = 1'b0; qw();
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qw(); scl = 1'b1; qw(); b[i] = sda_line; qw(); scl = 1'b0; qw();
        end
        m_sda = nack; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw(); m_sda = 1'b1;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] v, input string req);
        logic ack;
        bus_start();
        send_byte(8'hD2, ack); chk(req, ack, 1);
        send_byte(a, ack);     chk(req, ack, 1);
        send_byte(v, ack);     chk(req, ack, 1);
        bus_stop();
        if (b_impl(a)) mdl[a] = b_store(a, v);
    endtask

    task automatic rd_burst(input logic [7:0] a, input int n, input string req);
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD2, ack); chk(req, ack, 1);
        send_byte(a, ack);     chk(req, ack, 1);
        bus_start();
        send_byte(8'hD3, ack); chk(req, ack, 1);
        for (int i = 0; i < n; i++) begin
            logic [7:0] ad;
            ad = a + 8'(i);
            recv_byte(i == n - 1, b);
            chk(req, b, b_impl(ad) ? mdl[ad] : 8'h00);
        end
        bus_stop();
    endtask

    task automatic chk_image(input string req);
        for (int k = 0; k < 11; k++) chk(req, image[k*8 +: 8], mdl[b_list(k)]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic ack;
        for (int a = 0; a < 256; a++) mdl[a] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset state
        chk("R1 pull", sda_pull, 0);
        chk("R1 flag", resv_flag, 0);
        chk("R1 image", image == '0, 1);

        // R2: bytes clocked without a start are not acknowledged
        scl = 1'b0; qw();
        send_byte(8'hD2, ack); chk("R2 no start", ack, 0);
        send_byte(8'h09, ack); chk("R2 no start", ack, 0);
        bus_stop();
        chk("R2 released", sda_pull, 0);

        // R3: wrong device address is ignored until the next start
        bus_start();
        send_byte(8'hA0, ack); chk("R3 mismatch", ack, 0);
        send_byte(8'h09, ack); chk("R3 mismatch", ack, 0);
        send_byte(8'hFF, ack); chk("R3 mismatch", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'hD3 ^ 8'h02, ack); chk("R3 mismatch read", ack, 0);
        bus_stop();
        chk_image("R3 image");

        // R4 / R8: single writes with fixed patterns
        wr_reg(8'h09, 8'hFF, "R4 R8 09");
        wr_reg(8'h12, 8'hFF, "R8 12");
        wr_reg(8'h40, 8'h00, "R8 40");
        wr_reg(8'h46, 8'h00, "R8 46");
        wr_reg(8'h0C, 8'h8B, "R4 0C");
        chk_image("R9 image");
        chk("R7 flag clear", resv_flag, 0);

        // R5: burst write into 44..47
        bus_start();
        send_byte(8'hD2, ack); chk("R5 burst", ack, 1);
        send_byte(8'h44, ack); chk("R5 burst", ack, 1);
        for (int i = 0; i < 4; i++) begin
            logic [7:0] v;
            v = 8'h5A + 8'(i * 17);
            send_byte(v, ack); chk("R5 burst ack", ack, 1);
            mdl[8'h44 + 8'(i)] = b_store(8'h44 + 8'(i), v);
        end
        bus_stop();
        chk_image("R5 image");

        // R6: read across stored and reserved addresses, NACK ends
        rd_burst(8'h09, 4, "R6 read");
        rd_burst(8'h45, 4, "R6 R7 read");
        chk("R6 released", sda_pull, 0);

        // R7: reserved write acked, ignored, flag sticks
        wr_reg(8'h20, 8'h77, "R7 ack");
        chk("R7 flag", resv_flag, 1);
        chk_image("R7 image");

        // R5: pointer wrap FFH -> 00H lands last byte of a 26-byte burst on 09H
        bus_start();
        send_byte(8'hD2, ack); chk("R5 wrap", ack, 1);
        send_byte(8'hF0, ack); chk("R5 wrap", ack, 1);
        for (int i = 0; i < 26; i++) begin
            logic [7:0] ad;
            ad = 8'hF0 + 8'(i);
            send_byte(8'hC0 + 8'(i), ack); chk("R5 wrap ack", ack, 1);
            if (b_impl(ad)) mdl[ad] = b_store(ad, 8'hC0 + 8'(i));
        end
        bus_stop();
        chk("R5 wrap 09", image[7:0], 8'h19);
        rd_burst(8'hFE, 12, "R5 read wrap");

        // Exhaustive: write every address in one burst, read all back
        bus_start();
        send_byte(8'hD2, ack); chk("R4 sweep", ack, 1);
        send_byte(8'h00, ack); chk("R4 sweep", ack, 1);
        for (int a = 0; a < 256; a++) begin
            logic [7:0] v;
            v = 8'(a * 37 + 11);
            send_byte(v, ack); chk("R4 R7 sweep ack", ack, 1);
            if (b_impl(8'(a))) mdl[a] = b_store(8'(a), v);
        end
        bus_stop();
        chk_image("R8 R9 sweep image");
        rd_burst(8'h00, 256, "R6 R7 sweep read");
        chk("R7 flag end", resv_flag, 1);

        // R1: reset clears everything again
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 re-reset image", image == '0, 1);
        chk("R1 re-reset flag", resv_flag, 0);
        chk("R1 re-reset pull", sda_pull, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule